// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small fully associative translation buffer for a 32-bit virtual address space with 4 KB pages. Each entry pairs a virtual page number with a physical page number and carries an 8-bit address-space tag. Because the tag is part of the match, up to 256 processes can keep translations resident together, and a process switch only changes the current tag input. Nothing has to be flushed.

Entries can be marked global, which makes them match under every tag. This suits the kernel half of the address space, which is shared by all processes. Each entry also holds two permission bits. One forbids instruction fetch. The other allows writes.

A lookup presents a virtual address, the current tag and an access kind. One clock later the block returns four things: hit or miss, the physical address, a permission fault flag, and, on a miss, which of the two translation base registers a table walk would use. The upper half of the address space uses one base and the lower half uses the other. A refill port writes entries into slots chosen round-robin. Invalidate-all and invalidate-by-tag commands remove entries.

Top module: `xlat_tlb`

## Requirements
- R1: After a synchronous reset, rsp_valid is 0, every entry is invalid, so the first lookup misses, and the refill slot pointer points at slot 0.
- R2: A lookup made with req_valid high in cycle N gives rsp_valid high in cycle N+1. In a cycle where rsp_valid is low, rsp_hit, rsp_fault, rsp_pa and rsp_base_sel are all 0.
- R3: A lookup hits when a valid entry's page number equals req_va[31:12] and its tag rule passes. On a hit without a fault, rsp_pa is {entry page, req_va[11:0]}. When several entries match, the lowest slot index wins.
- R4: A non-global entry matches only when its stored tag equals req_asid. Changing req_asid removes no entry, so switching back to the old tag hits again.
- R5: A global entry matches whatever the value of req_asid.
- R6: An access kind of 0 (instruction fetch) that hits an entry whose execute-never bit is set gives rsp_hit=1, rsp_fault=1 and rsp_pa=0.
- R7: An access kind of 2 (write) that hits an entry whose write-enable bit is clear gives rsp_hit=1, rsp_fault=1 and rsp_pa=0. Kinds 1 and 3 are reads, and reads never fault.
- R8: On a miss, rsp_base_sel equals req_va[31]: 1 selects the kernel-half base and 0 selects the per-process base. rsp_pa is 0. On a hit, rsp_base_sel is 0.
- R9: Refills go to slots 0, 1, ..., ENTRIES-1 in turn and then wrap. Refill number ENTRIES+1 after reset overwrites the first entry that was written.
- R10: A refill accepted at the clock edge ending cycle N is seen by lookups issued in cycle N+1. A lookup issued in the same cycle as the refill sees the old contents.
- R11: inv_all clears every entry, global ones included. A refill in the same cycle still writes its own slot.
- R12: inv_asid_valid clears only the non-global entries whose tag equals inv_asid. When inv_all is also high, inv_all takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address to translate |
| req_asid | input | 8 | Current address-space tag |
| req_kind | input | 2 | Access kind: 0 fetch, 1 read, 2 write, 3 read |
| fill_valid | input | 1 | Refill write strobe |
| fill_vpn | input | 20 | Refill virtual page number |
| fill_ppn | input | 20 | Refill physical page number |
| fill_asid | input | 8 | Refill tag |
| fill_global | input | 1 | Refill entry matches every tag |
| fill_xn | input | 1 | Refill entry forbids instruction fetch |
| fill_wr | input | 1 | Refill entry allows writes |
| inv_all | input | 1 | Invalidate every entry |
| inv_asid_valid | input | 1 | Invalidate non-global entries of one tag |
| inv_asid | input | 8 | Tag for invalidate-by-tag |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_hit | output | 1 | A matching entry was found |
| rsp_pa | output | 32 | Translated address, 0 on a miss or a fault |
| rsp_fault | output | 1 | Permission fault on a hit |
| rsp_base_sel | output | 1 | Translation base a walk would use on a miss |

## Verification
The bench covers several cases where a plausible mistake gives a wrong answer. A lookup issued in the same cycle as a refill must still miss, and a design that forwards the refill would hit too early. A tag switch away from a process and back must hit again, which catches a design that flushes on a tag change or ignores the tag altogether. Invalidate-by-tag must spare global entries and entries of other tags, and a design that clears too widely loses kernel translations. Fetch and write checks run against entries with each permission combination, which catches swapped permission bits or a fault on a read. Round-robin wrap checks that the seventeenth refill evicts the oldest entry and not some other slot. Random traffic then runs over a small page pool, so duplicate matches occur and test the lowest-slot priority.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
    localparam int VA_W     = 32;
    localparam int PA_W     = 32;
    localparam int PG_SHIFT = 12;
    localparam int ASID_W   = 8;
    localparam int VPN_W    = VA_W - PG_SHIFT;
    localparam int PPN_W    = PA_W - PG_SHIFT;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    typedef struct packed {
        logic              valid;
        logic              glob;
        logic              xn;
        logic              wr;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
    } tlb_ent_t;

    function automatic logic ent_match(tlb_ent_t e, logic [VPN_W-1:0] vpn,
                                       logic [ASID_W-1:0] asid);
        return e.valid && (e.vpn == vpn) && (e.glob || (e.asid == asid));
    endfunction

    function automatic logic perm_fault(tlb_ent_t e, acc_e kind);
        return ((kind == ACC_FETCH) && e.xn) || ((kind == ACC_WRITE) && !e.wr);
    endfunction
endpackage

// File: rtl/xlat_victim_ptr.sv
`timescale 1ns/1ps
module xlat_victim_ptr #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [IDX_W-1:0] idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (adv) begin
            if (idx == IDX_W'(ENTRIES - 1)) idx <= '0;
            else                            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/xlat_entry_store.sv
`timescale 1ns/1ps
module xlat_entry_store
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      fill_valid,
    input  logic [IDX_W-1:0]          fill_idx,
    input  tlb_ent_t                  fill_ent,
    input  logic                      inv_all,
    input  logic                      inv_asid_valid,
    input  logic [ASID_W-1:0]         inv_asid,
    output tlb_ent_t [ENTRIES-1:0]    ents
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[i] <= '0;
            end else begin
                if (inv_all)
                    ents[i].valid <= 1'b0;
                else if (inv_asid_valid && !ents[i].glob && (ents[i].asid == inv_asid))
                    ents[i].valid <= 1'b0;
                if (fill_valid && (fill_idx == IDX_W'(i)))
                    ents[i] <= fill_ent;
            end
        end
    end
endmodule

// File: rtl/xlat_match.sv
`timescale 1ns/1ps
module xlat_match
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  tlb_ent_t [ENTRIES-1:0] ents,
    input  logic [VPN_W-1:0]       vpn,
    input  logic [ASID_W-1:0]      asid,
    output logic                   hit,
    output tlb_ent_t               sel
);
    logic [ENTRIES-1:0] hv;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hv[i] = ent_match(ents[i], vpn, asid);
    end

    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hv[i]) sel = ents[i];
        end
        hit = |hv;
    end
endmodule

// File: rtl/xlat_tlb.sv
`timescale 1ns/1ps
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [1:0]        req_kind,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_global,
    input  logic              fill_xn,
    input  logic              fill_wr,
    input  logic              inv_all,
    input  logic              inv_asid_valid,
    input  logic [ASID_W-1:0] inv_asid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_fault,
    output logic              rsp_base_sel
);
    tlb_ent_t [ENTRIES-1:0] ents;
    tlb_ent_t               fill_ent;
    tlb_ent_t               sel;
    logic [IDX_W-1:0]       victim;
    logic                   m_hit;
    logic                   m_fault;

    assign fill_ent = '{valid: 1'b1, glob: fill_global, xn: fill_xn, wr: fill_wr,
                        asid: fill_asid, vpn: fill_vpn, ppn: fill_ppn};

    xlat_victim_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk (clk), .rst (rst), .adv (fill_valid), .idx (victim)
    );

    xlat_entry_store #(.ENTRIES(ENTRIES)) u_store (
        .clk (clk), .rst (rst),
        .fill_valid (fill_valid), .fill_idx (victim), .fill_ent (fill_ent),
        .inv_all (inv_all), .inv_asid_valid (inv_asid_valid), .inv_asid (inv_asid),
        .ents (ents)
    );

    xlat_match #(.ENTRIES(ENTRIES)) u_match (
        .ents (ents), .vpn (req_va[VA_W-1:PG_SHIFT]), .asid (req_asid),
        .hit (m_hit), .sel (sel)
    );

    assign m_fault = m_hit && perm_fault(sel, acc_e'(req_kind));

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_fault    <= 1'b0;
            rsp_pa       <= '0;
            rsp_base_sel <= 1'b0;
        end else begin
            rsp_valid    <= 1'b1;
            rsp_hit      <= m_hit;
            rsp_fault    <= m_fault;
            rsp_pa       <= (m_hit && !m_fault) ? {sel.ppn, req_va[PG_SHIFT-1:0]} : '0;
            rsp_base_sel <= !m_hit && req_va[VA_W-1];
        end
    end
endmodule

// File: rtl/xlat_tlb_chk.sv
`timescale 1ns/1ps
module xlat_tlb_chk
    import xlat_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [VA_W-1:0] req_va,
    input logic            fill_valid,
    input logic            inv_all,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic [PA_W-1:0] rsp_pa,
    input logic            rsp_fault,
    input logic            rsp_base_sel
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !rsp_valid);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_hit || rsp_fault || rsp_base_sel || (rsp_pa != '0)));

    // R6
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_hit);

    // R8
    miss_base_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_pa == '0 && rsp_base_sel == $past(req_va[VA_W-1])));

    // R11
    flushed_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && $past(inv_all) && !$past(fill_valid) && !$past(rst)) |=> !rsp_hit);
endmodule

bind xlat_tlb xlat_tlb_chk chk_i (
    .clk (clk), .rst (rst), .req_valid (req_valid), .req_va (req_va),
    .fill_valid (fill_valid), .inv_all (inv_all),
    .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_pa (rsp_pa),
    .rsp_fault (rsp_fault), .rsp_base_sel (rsp_base_sel)
);

// File: tb/xlat_tlb_tb_top.sv
`timescale 1ns/1ps
module xlat_tlb_tb_top;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [7:0]  req_asid = '0;
    logic [1:0]  req_kind = '0;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic [7:0]  fill_asid = '0;
    logic        fill_global = 1'b0;
    logic        fill_xn = 1'b0;
    logic        fill_wr = 1'b0;
    logic        inv_all = 1'b0;
    logic        inv_asid_valid = 1'b0;
    logic [7:0]  inv_asid = '0;
    logic        rsp_valid, rsp_hit, rsp_fault, rsp_base_sel;
    logic [31:0] rsp_pa;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference entries
    bit          m_v [N];
    bit          m_g [N];
    bit          m_x [N];
    bit          m_w [N];
    logic [7:0]  m_a [N];
    logic [19:0] m_vpn [N];
    logic [19:0] m_ppn [N];
    int          m_ptr = 0;

    always #5 clk = ~clk;

    xlat_tlb #(.ENTRIES(N)) dut_i (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_va (req_va),
        .req_asid (req_asid), .req_kind (req_kind), .fill_valid (fill_valid),
        .fill_vpn (fill_vpn), .fill_ppn (fill_ppn), .fill_asid (fill_asid),
        .fill_global (fill_global), .fill_xn (fill_xn), .fill_wr (fill_wr),
        .inv_all (inv_all), .inv_asid_valid (inv_asid_valid), .inv_asid (inv_asid),
        .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_pa (rsp_pa),
        .rsp_fault (rsp_fault), .rsp_base_sel (rsp_base_sel)
    );

    // expected {valid, hit, fault, base, pa}
    function automatic logic [35:0] expect_rsp(logic [31:0] va, logic [7:0] asid, logic [1:0] kind);
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_vpn[i] == va[31:12] && (m_g[i] || m_a[i] == asid)) begin
                if ((kind == 2'd0 && m_x[i]) || (kind == 2'd2 && !m_w[i]))
                    return {1'b1, 1'b1, 1'b1, 1'b0, 32'd0};
                return {1'b1, 1'b1, 1'b0, 1'b0, m_ppn[i], va[11:0]};
            end
        end
        return {1'b1, 1'b0, 1'b0, va[31], 32'd0};
    endfunction

    task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual v/h/f/b/pa=%b%b%b%b/%h expected %b%b%b%b/%h", tag,
                     act[35], act[34], act[33], act[32], act[31:0],
                     exp[35], exp[34], exp[33], exp[32], exp[31:0]);
        end
    endtask

    function automatic logic [35:0] got();
        return {rsp_valid, rsp_hit, rsp_fault, rsp_base_sel, rsp_pa};
    endfunction

    task automatic model_fill(logic [19:0] vpn, logic [19:0] ppn, logic [7:0] a, bit g, bit x, bit w);
        m_v[m_ptr] = 1; m_g[m_ptr] = g; m_x[m_ptr] = x; m_w[m_ptr] = w;
        m_a[m_ptr] = a; m_vpn[m_ptr] = vpn; m_ppn[m_ptr] = ppn;
        m_ptr = (m_ptr + 1) % N;
    endtask

    task automatic fill(logic [19:0] vpn, logic [19:0] ppn, logic [7:0] a, bit g, bit x, bit w);
        @(negedge clk);
        fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn; fill_asid = a;
        fill_global = g; fill_xn = x; fill_wr = w;
        @(negedge clk);
        fill_valid = 0;
        model_fill(vpn, ppn, a, g, x, w);
    endtask

    task automatic look(string tag, logic [31:0] va, logic [7:0] asid, logic [1:0] kind);
        logic [35:0] exp;
        @(negedge clk);
        req_valid = 1; req_va = va; req_asid = asid; req_kind = kind;
        exp = expect_rsp(va, asid, kind);
        @(negedge clk);
        req_valid = 0;
        check(tag, got(), exp);
    endtask

    task automatic inv(bit all, bit by_tag, logic [7:0] a);
        @(negedge clk);
        inv_all = all; inv_asid_valid = by_tag; inv_asid = a;
        @(negedge clk);
        inv_all = 0; inv_asid_valid = 0;
        for (int i = 0; i < N; i++)
            if (all || (by_tag && !m_g[i] && m_a[i] == a)) m_v[i] = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [35:0] e;
        void'($urandom(32'd2024));
        for (int i = 0; i < N; i++) m_v[i] = 0;
        repeat (3) @(negedge clk);
        // R1 response idle while reset held
        check("R1 reset idle", got(), 36'd0);
        rst = 0;
        // R1 empty after reset, R8 user-half base
        look("R1 empty miss", 32'h0001_0123, 8'd5, 2'd1);
        look("R8 kernel miss base", 32'h8005_0000, 8'd5, 2'd1);
        // R2 idle after response
        @(negedge clk);
        check("R2 idle outputs", got(), 36'd0);
        // R3 basic hit
        fill(20'h00010, 20'h0ABCD, 8'd5, 0, 0, 1);
        look("R3 hit pa", 32'h0001_0123, 8'd5, 2'd1);
        // R4 tag switch and back
        look("R4 other tag miss", 32'h0001_0123, 8'd6, 2'd1);
        look("R4 switch back hit", 32'h0001_0FFF, 8'd5, 2'd2);
        // R5 global kernel entry, R6/R7 permissions
        fill(20'h80001, 20'h12345, 8'd0, 1, 1, 0);
        look("R5 global any tag", 32'h8000_1ABC, 8'd9, 2'd1);
        look("R6 fetch xn fault", 32'h8000_1ABC, 8'd9, 2'd0);
        look("R7 write ro fault", 32'h8000_1004, 8'd200, 2'd2);
        look("R7 kind3 read ok", 32'h8000_1004, 8'd200, 2'd3);
        look("R6 fetch allowed", 32'h0001_0010, 8'd5, 2'd0);
        // R10 refill and lookup in same cycle
        @(negedge clk);
        fill_valid = 1; fill_vpn = 20'h00022; fill_ppn = 20'h00777; fill_asid = 8'd5;
        fill_global = 0; fill_xn = 0; fill_wr = 1;
        req_valid = 1; req_va = 32'h0002_2008; req_asid = 8'd5; req_kind = 2'd1;
        e = expect_rsp(32'h0002_2008, 8'd5, 2'd1);
        @(negedge clk);
        fill_valid = 0; req_valid = 0;
        model_fill(20'h00022, 20'h00777, 8'd5, 0, 0, 1);
        check("R10 same-cycle miss", got(), e);
        look("R10 next-cycle hit", 32'h0002_2008, 8'd5, 2'd1);
        // R12 invalidate by tag spares global and other tags
        fill(20'h00033, 20'h00333, 8'd7, 0, 0, 1);
        inv(0, 1, 8'd5);
        look("R12 tag cleared", 32'h0001_0123, 8'd5, 2'd1);
        look("R12 global kept", 32'h8000_1000, 8'd5, 2'd1);
        look("R12 other tag kept", 32'h0003_3000, 8'd7, 2'd1);
        // R9 round-robin wrap
        for (int k = 0; k < N + 1; k++)
            fill(20'h00100 + 20'(k), 20'h0F000 + 20'(k), 8'd3, 0, 0, 1);
        look("R9 oldest evicted", 32'h8000_1000, 8'd3, 2'd1);
        look("R9 wrapped slot hit", 32'h0011_0000, 8'd3, 2'd1);
        look("R9 first batch evicted", 32'h0010_0000, 8'd3, 2'd1);
        look("R9 kept entry", 32'h0010_5000, 8'd3, 2'd1);
        // R11 invalidate all
        inv(1, 0, 8'd0);
        look("R11 all cleared", 32'h0010_5000, 8'd3, 2'd1);
        // random mix: R3 R4 R5 R6 R7 R8 R9 R11 R12
        for (int it = 0; it < 600; it++) begin
            int op;
            logic [19:0] vpn;
            op = int'($urandom_range(0, 9));
            vpn = {$urandom_range(0, 1) == 1, 14'd0, 5'($urandom_range(0, 31))};
            if (op < 3)
                fill(vpn, 20'($urandom), 8'($urandom_range(0, 3)), $urandom_range(0, 3) == 0,
                     $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
            else if (op == 3 && $urandom_range(0, 9) == 0)
                inv(1, 0, 8'd0);
            else if (op == 3)
                inv(0, 1, 8'($urandom_range(0, 3)));
            else
                look("R3 random lookup", {vpn, 12'($urandom)}, 8'($urandom_range(0, 3)),
                     2'($urandom_range(0, 3)));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule